// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (a clock line and an open-drain data line) that lets a host load and read back a small bank of byte-wide control registers. It runs entirely from a fast system clock: both bus lines are brought in through two-flop synchronizers, and clock edges, start conditions and stop conditions are recognized as events in the system-clock domain. The data line is driven only low, through an output-enable; the pull-up belongs to the board.

Transfers use a block framing. A write starts with the write address byte, then a command byte and a count byte. Both are acknowledged and then discarded. The data bytes that follow fill the registers from index 0 upward until the stop. A read starts with the read address byte. The slave then returns the number of implemented registers, followed by the registers in order, until the master declines a byte. Every register has a fixed reset value, so the chip it configures runs sensibly even when nothing on the bus ever writes to it.

The register contents are presented in parallel on a flat output vector, register k occupying bits 8k+7 down to 8k.

Top module: `ctlbank_twi`

## Requirements
- R1: After reset, register k holds 8'hC0 + k and `sda_oe` is 0.
- R2: A falling data line while the clock is high is a start and restarts address reception from any state. A rising data line while the clock is high is a stop: it releases the data line, and bytes clocked after it are not acknowledged until the next start.
- R3: Bytes are shifted MSB first, sampled on the rising clock. Each byte the slave accepts is acknowledged by asserting `sda_oe` (pulling data low) for the ninth clock.
- R4: The address byte 8'hD2 (7-bit address 7'h69, R/W bit 0) is acknowledged. The two bytes after it, a command byte and a count byte, are acknowledged whatever their values and change no register.
- R5: Data bytes after the count byte are stored into register 0, 1, 2 and so on, in order, until the stop.
- R6: Data bytes beyond the last implemented register are acknowledged and discarded.
- R7: The address byte 8'hD3 (R/W bit 1) is acknowledged. The slave then sends the number of implemented registers, then register 0, 1 and so on in order, and 8'h00 for every position past the last register.
- R8: When the master does not acknowledge a byte during a read, the slave releases the data line and drives nothing more until the next start.
- R9: An address byte that is neither 8'hD2 nor 8'hD3 is not acknowledged, and every byte up to the next start is ignored.
- R10: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (resolved wired-AND) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_q | output | 8*NUM_REGS | Register contents, register k at bits 8k+7:8k |

## Verification
A wrong protocol state shows on the data line within one bus bit. A lost or misplaced acknowledge shows on the ninth clock of the byte in which the state went wrong. A read byte that is shifted wrongly or taken from the wrong register differs at the first wrong bit. A wrong write index or a wrong phase in the framing corrupts `reg_q` one system clock after the ninth clock of the data byte concerned. A slave that fails to drop back to idle after a stop, a bad address or a master NACK shows up as an acknowledge or a driven bit on the next byte clocked before a new start.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;

    // 7-bit bus address; the R/W bit is appended on the wire
    localparam logic [6:0] TW_DEV_ADDR = 7'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tw_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } tw_phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } tw_bus_ev_t;

    function automatic logic [7:0] reg_default(input int unsigned k);
        return 8'(32'hC0 + k);
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync
    import tw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_lvl,
    output tw_bus_ev_t ev
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [STAGES-1:0] chain [NLINES];
    logic              prev  [NLINES];
    logic              cur   [NLINES];

    assign raw = {scl_i, sda_i};

    for (genvar L = 0; L < NLINES; L++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[L] <= '1;
                prev[L]  <= 1'b1;
            end else begin
                chain[L] <= {chain[L][STAGES-2:0], raw[L]};
                prev[L]  <= chain[L][STAGES-1];
            end
        end
        assign cur[L] = chain[L][STAGES-1];
    end

    // index 1 = clock line, index 0 = data line
    assign scl_lvl     = cur[1];
    assign ev.scl_rise = cur[1] & ~prev[1];
    assign ev.scl_fall = ~cur[1] & prev[1];
    assign ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
    assign ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    assign ev.sda      = cur[0];

endmodule

// File: rtl/tw_proto_fsm.sv
`timescale 1ns/1ps
module tw_proto_fsm
    import tw_pkg::*;
#(
    parameter int         NUM_REGS = 4,
    parameter int         IDXW     = 3,
    parameter logic [6:0] DEV_ADDR = TW_DEV_ADDR
) (
    input  logic            clk,
    input  logic            rst,
    input  tw_bus_ev_t      ev,
    input  logic [7:0]      rd_data,
    output logic [IDXW-1:0] rd_idx,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic            sda_oe
);

    localparam logic [7:0] WR_BYTE  = {DEV_ADDR, 1'b0};
    localparam logic [7:0] RD_BYTE  = {DEV_ADDR, 1'b1};
    localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);
    localparam logic [IDXW-1:0] IDX_END = IDXW'(NUM_REGS);

    tw_state_e       state;
    tw_phase_e       phase;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic            rd_mode;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] idx_next;

    always_comb idx_next = (idx == IDX_END) ? idx : idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            rd_mode <= 1'b0;
            idx     <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state  <= ST_RX;
                phase  <= PH_ADDR;
                bitcnt <= '0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            unique case (phase)
                                PH_ADDR: begin
                                    if (shreg == WR_BYTE) begin
                                        rd_mode <= 1'b0;
                                        phase   <= PH_CMD;
                                        state   <= ST_RX_ACK;
                                    end else if (shreg == RD_BYTE) begin
                                        rd_mode <= 1'b1;
                                        state   <= ST_RX_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_CMD: begin
                                    phase <= PH_CNT;
                                    state <= ST_RX_ACK;
                                end
                                PH_CNT: begin
                                    phase <= PH_DATA;
                                    idx   <= '0;
                                    state <= ST_RX_ACK;
                                end
                                PH_DATA: begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= shreg;
                                    idx     <= idx_next;
                                    state   <= ST_RX_ACK;
                                end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                shreg <= CNT_BYTE;
                                idx   <= '0;
                                state <= ST_TX;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state <= ST_TX_ACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise && ev.sda) begin
                            state <= ST_IDLE;
                        end else if (ev.scl_fall) begin
                            shreg  <= rd_data;
                            idx    <= idx_next;
                            bitcnt <= '0;
                            state  <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_idx = idx;
    assign sda_oe = (state == ST_RX_ACK) || (state == ST_TX && !shreg[7]);

endmodule

// File: rtl/tw_reg_bank.sv
`timescale 1ns/1ps
module tw_reg_bank
    import tw_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDXW     = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [NUM_REGS-1:0][7:0] regs;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= reg_default(k);
            else if (wr_en && wr_idx == IDXW'(k))
                regs[k] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_REGS; k++)
            if (rd_idx == IDXW'(k))
                rd_data = regs[k];
    end

    assign regs_flat = regs;

endmodule

// File: rtl/ctlbank_twi.sv
`timescale 1ns/1ps
module ctlbank_twi
    import tw_pkg::*;
#(
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = TW_DEV_ADDR
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_q
);

    localparam int IDXW = $clog2(NUM_REGS + 1);

    tw_bus_ev_t      bus_ev;
    logic            scl_lvl;
    logic [7:0]      rd_data;
    logic [IDXW-1:0] rd_idx;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .ev      (bus_ev)
    );

    tw_proto_fsm #(.NUM_REGS(NUM_REGS), .IDXW(IDXW), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (bus_ev),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    tw_reg_bank #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (reg_q)
    );

endmodule

// File: rtl/tw_slave_chk.sv
`timescale 1ns/1ps
module tw_slave_chk #(
    parameter int NUM_REGS = 4,
    parameter int IDXW     = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_lvl,
    input logic                  stop_ev,
    input logic                  sda_oe,
    input logic                  wr_en,
    input logic [IDXW-1:0]       wr_idx,
    input logic [NUM_REGS*8-1:0] reg_q
);

    // R10
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    // R10
    oe_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_lvl);

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    // R5
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(reg_q));

    // R6
    overflow_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IDXW'(NUM_REGS)) |=> $stable(reg_q));

endmodule

bind ctlbank_twi tw_slave_chk #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (scl_lvl),
    .stop_ev (bus_ev.stop),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .reg_q   (reg_q)
);

// File: tb/ctlbank_twi_test.sv
`timescale 1ns/1ps
module ctlbank_twi_test;

    localparam int NR = 4;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_oe;
    wire  [NR*8-1:0] reg_q;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;

    ctlbank_twi #(.NUM_REGS(NR)) uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .reg_q  (reg_q)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst && scl_m && sda_oe != oe_prev) oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input logic [7:0] e3);
        logic [7:0] exp [NR];
        exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
        for (int k = 0; k < NR; k++) check8(tag, reg_q[8*k +: 8], exp[k]);
    endtask

    task automatic q_wait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; q_wait;
        scl_m = 1'b1; q_wait;
        sda_m = 1'b0; q_wait;
        scl_m = 1'b0; q_wait;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; q_wait;
        scl_m = 1'b1; q_wait;
        sda_m = 1'b1; q_wait;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q_wait;
            scl_m = 1'b1; q_wait; q_wait;
            scl_m = 1'b0; q_wait;
        end
        sda_m = 1'b1; q_wait;
        scl_m = 1'b1; q_wait;
        acked = ~sda_line; q_wait;
        scl_m = 1'b0; q_wait;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; q_wait;
            scl_m = 1'b1; q_wait;
            b[i] = sda_line; q_wait;
            scl_m = 1'b0; q_wait;
        end
        sda_m = ~give_ack; q_wait;
        scl_m = 1'b1; q_wait; q_wait;
        scl_m = 1'b0; q_wait;
        sda_m = 1'b1;
    endtask

    task automatic t_reset;
        check_regs("R1 reset value", 8'hC0, 8'hC1, 8'hC2, 8'hC3);
        check8("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_header_only;
        logic a;
        bus_start;
        send_byte(8'hD2, a); check8("R4 write address ack", {7'd0, a}, 8'h01);
        send_byte(8'h77, a); check8("R4 command ack", {7'd0, a}, 8'h01);
        send_byte(8'h55, a); check8("R4 count ack", {7'd0, a}, 8'h01);
        bus_stop;
        check_regs("R4 header leaves registers", 8'hC0, 8'hC1, 8'hC2, 8'hC3);
    endtask

    task automatic t_write_basic;
        logic a;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h02, a);
        send_byte(8'h3C, a); check8("R3 data ack", {7'd0, a}, 8'h01);
        send_byte(8'hA5, a); check8("R3 data ack", {7'd0, a}, 8'h01);
        bus_stop;
        check_regs("R5 ordered fill", 8'h3C, 8'hA5, 8'hC2, 8'hC3);
    endtask

    task automatic t_write_overflow;
        logic a;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        for (int i = 1; i <= 6; i++) begin
            send_byte(8'(i), a);
            check8("R6 ack incl. past end", {7'd0, a}, 8'h01);
        end
        bus_stop;
        check_regs("R6 overflow discarded", 8'h01, 8'h02, 8'h03, 8'h04);
    endtask

    task automatic t_read;
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte(8'hD3, a); check8("R7 read address ack", {7'd0, a}, 8'h01);
        recv_byte(1'b1, b); check8("R7 byte count", b, 8'(NR));
        for (int k = 0; k < NR; k++) begin
            recv_byte(1'b1, b); check8("R7 register readback", b, 8'(k + 1));
        end
        recv_byte(1'b1, b); check8("R7 past end", b, 8'h00);
        recv_byte(1'b0, b); check8("R7 past end", b, 8'h00);
        check8("R8 released after NACK", {7'd0, sda_oe}, 8'h00);
        recv_byte(1'b0, b); check8("R8 silent after NACK", b, 8'hFF);
        bus_stop;
    endtask

    task automatic t_bad_addr;
        logic a;
        bus_start;
        send_byte(8'hA0, a); check8("R9 foreign address", {7'd0, a}, 8'h00);
        send_byte(8'hD2, a); check8("R9 ignored until start", {7'd0, a}, 8'h00);
        send_byte(8'h00, a); check8("R9 ignored until start", {7'd0, a}, 8'h00);
        bus_stop;
        check_regs("R9 registers untouched", 8'h01, 8'h02, 8'h03, 8'h04);
    endtask

    task automatic t_stop_idle;
        logic a;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_stop;
        check8("R2 released at stop", {7'd0, sda_oe}, 8'h00);
        send_byte(8'hD2, a); check8("R2 no ack after stop", {7'd0, a}, 8'h00);
        bus_stop;
    endtask

    task automatic t_restart;
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_start;
        send_byte(8'hD3, a); check8("R2 repeated start address", {7'd0, a}, 8'h01);
        recv_byte(1'b1, b); check8("R2 count after restart", b, 8'(NR));
        recv_byte(1'b0, b); check8("R2 reg0 after restart", b, 8'h01);
        bus_stop;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset;
        t_header_only;
        t_write_basic;
        t_write_overflow;
        t_read;
        t_bad_addr;
        t_stop_idle;
        t_restart;
        checks++;
        if (oe_viol != 0) begin
            errors++;
            $display("FAIL R10 oe changes with clock high actual=%0d expected=0", oe_viol);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule